// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 station-management master for external PHY devices. Software sets it up through a small register port: a control word selects the management-clock divisor and turns the interface on, a data register holds the value for the next write, and an access word names the PHY, the register within it and the direction. Writing the access word starts one 64-bit management frame. The block generates MDC from the system clock, shifts the frame out on MDIO, and drives the tristate enable.

A write frame carries the staged 16-bit value to the PHY. A read frame releases the line after the register address and samples 16 bits from the PHY. The result is then available in a read-data register. A busy output stays high for the whole frame. Between frames MDC rests low and MDIO is released, so the board pull-up holds the line high.

Top module: `mdio_master`

## Requirements
- R1: After reset the control register reads 0x003F: divisor 63, interface disabled. busy, mdc and mdio_oe are all low.
- R2: Register addresses are 0 for control, 1 for write data, 2 for access and 3 for read data. Control bits [5:0] hold the divisor and bit 6 is the enable. Both read back as written.
- R3: MDC high and low phases each last divisor+1 system clocks. A frame lasts exactly 64 MDC periods, so busy stays high for 128*(divisor+1) system clocks.
- R4: The access word has the PHY address in bits [9:5], the register address in bits [4:0], and a read flag in bit 10 (1 = read). A write frame drives these bits, in this order: 32 ones, start 01, opcode 01, PHY address MSB first, register address MSB first, turnaround 10, then the write-data register MSB first.
- R5: MDIO output and its enable change only at MDC falling edges. They are stable across every MDC rising edge.
- R6: A read frame drives opcode 10 and releases mdio_oe from the first turnaround bit to the end of the frame. It samples mdio_i on 16 MDC rising edges, MSB first. The value then reads back at address 3 once busy clears.
- R7: While no frame is in progress, mdc is low and mdio_oe is low.
- R8: While the enable bit is clear, an access write starts no frame: busy stays low and MDC does not toggle.
- R9: An access write while busy is ignored. The running frame keeps its timing, and the access register keeps the word of the running frame.
- R10: busy is high in the clock cycle that follows an accepted access write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write value |
| reg_rdata | output | 16 | Register read value for reg_addr (combinational) |
| busy | output | 1 | Frame in progress |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line input |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Write and read frames run for divisors 1, 2, 3 and 7 and for the default 63. The frame duration measured from busy therefore separates a wrong divisor+1 count from a wrong bit count. The address and data patterns are all zeros, all ones, two alternating patterns and a pattern with single end bits. Together they expose swapped PHY and register fields, bit-order reversal and an off-by-one shift. Read frames return a PHY value different from the address bits, so the turnaround release and the sampling edge are told apart. A disabled start and a mid-frame access write check that those inputs leave frame timing and register state alone.

// File: rtl/mdio_pkg.sv
// Package: shared register addresses and frame code points for the MDIO master.
package mdio_pkg;
    typedef enum logic [1:0] {
        RA_CTRL   = 2'd0,
        RA_WDATA  = 2'd1,
        RA_ACCESS = 2'd2,
        RA_RDATA  = 2'd3
    } reg_addr_e;

    localparam logic [1:0] SOF_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;
    localparam logic [1:0] TA_READ  = 2'b11;
endpackage

// File: rtl/mdio_clkgen.sv
// mdio_clkgen: builds MDC from the system clock while run is high.
// Each MDC phase lasts div+1 system clocks. The single-cycle strobes mark the
// system edge on which MDC rises or falls. Assumes div >= 1.
// MDC is forced low whenever run is low.
module mdio_clkgen #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W-1:0] cnt_q;
    logic             wrap;

    // Phase end: the counter has reached the divisor.
    assign wrap     = run && (cnt_q == div);
    assign rise_stb = wrap && !mdc;
    assign fall_stb = wrap && mdc;

    // Phase counter and MDC toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_mdc_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_frame_engine.sv
// mdio_frame_engine: serialises one clause 22 frame per start pulse.
// Output bits advance on MDC falling strobes. Read data is sampled on MDC rising
// strobes. Assumes start is only given while idle and that the strobes come from
// mdio_clkgen running on busy. abort drops the frame at once.
module mdio_frame_engine #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned FLD_W   = 5,
    parameter int unsigned PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              is_read,
    input  logic [FLD_W-1:0]  phy_addr,
    input  logic [FLD_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rise_stb,
    input  logic              fall_stb,
    input  logic              mdio_i,
    output logic              busy,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data
);
    import mdio_pkg::*;

    localparam int unsigned FRAME_LEN = PRE_LEN + 6 + 2*FLD_W + DATA_W;
    localparam int unsigned IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(FRAME_LEN - DATA_W - 2);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(FRAME_LEN - DATA_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    logic [FRAME_LEN-1:0] frame_w;
    logic [FRAME_LEN-1:0] sh_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 rd_op_q;
    logic [DATA_W-1:0]    rd_sh_q;

    // Frame image assembled from the request, first bit at the top.
    always_comb begin
        frame_w = {{PRE_LEN{1'b1}}, SOF_CODE,
                   is_read ? OP_READ : OP_WRITE,
                   phy_addr, reg_addr,
                   is_read ? TA_READ : TA_WRITE,
                   is_read ? {DATA_W{1'b0}} : wr_data};
    end

    // Frame sequencer: load, shift on falling strobes, capture on rising strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx_q   <= '0;
            sh_q    <= '0;
            rd_op_q <= 1'b0;
            rd_sh_q <= '0;
            rd_data <= '0;
        end else if (abort) begin
            busy  <= 1'b0;
            idx_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                idx_q   <= '0;
                sh_q    <= frame_w;
                rd_op_q <= is_read;
            end
        end else begin
            if (rise_stb && rd_op_q && idx_q >= DATA_IDX)
                rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
            if (fall_stb) begin
                if (idx_q == LAST_IDX) begin
                    busy <= 1'b0;
                    if (rd_op_q)
                        rd_data <= rd_sh_q;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= sh_q << 1;
                end
            end
        end
    end

    // Line drive: current bit while the master owns the line.
    assign mdio_o  = busy ? sh_q[FRAME_LEN-1] : 1'b1;
    assign mdio_oe = busy && !(rd_op_q && idx_q >= TA_IDX);

    p_mdio_stable_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

// File: rtl/mdio_master.sv
// mdio_master: register-programmed clause 22 management master.
// It holds the control, write-data, access and read-data registers. An accepted
// access write launches a frame. Assumes software keeps the divisor at 1 or above.
// Clearing the enable aborts any running frame.
module mdio_master #(
    parameter int unsigned DIV_W   = 6,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned FLD_W   = 5,
    parameter int unsigned PRE_LEN = 32,
    parameter int unsigned REG_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             busy,
    output logic             mdc,
    input  logic             mdio_i,
    output logic             mdio_o,
    output logic             mdio_oe
);
    import mdio_pkg::*;

    localparam int unsigned ACC_W = 2*FLD_W + 1;

    logic [DIV_W-1:0]  div_q;
    logic              en_q;
    logic [DATA_W-1:0] wdata_q;
    logic [ACC_W-1:0]  acc_q;
    logic [DATA_W-1:0] rdata_w;
    logic              acc_we;
    logic              start;
    logic              rise_stb;
    logic              fall_stb;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[REG_W-1:ACC_W];
    assign acc_we = reg_we && (reg_addr == RA_ACCESS);
    assign start  = acc_we && en_q && !busy;

    // Control register: divisor and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '1;
            en_q  <= 1'b0;
        end else if (reg_we && reg_addr == RA_CTRL) begin
            div_q <= reg_wdata[DIV_W-1:0];
            en_q  <= reg_wdata[DIV_W];
        end
    end

    // Staged write data and the access word of the accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdata_q <= '0;
            acc_q   <= '0;
        end else begin
            if (reg_we && reg_addr == RA_WDATA)
                wdata_q <= reg_wdata[DATA_W-1:0];
            if (start)
                acc_q <= reg_wdata[ACC_W-1:0];
        end
    end

    // Register readback mux.
    always_comb begin
        case (reg_addr)
            RA_CTRL:   reg_rdata = REG_W'({en_q, div_q});
            RA_WDATA:  reg_rdata = REG_W'(wdata_q);
            RA_ACCESS: reg_rdata = REG_W'(acc_q);
            default:   reg_rdata = REG_W'(rdata_w);
        endcase
    end

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy && en_q),
        .div      (div_q),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_engine #(.DATA_W(DATA_W), .FLD_W(FLD_W), .PRE_LEN(PRE_LEN)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (!en_q),
        .is_read  (reg_wdata[ACC_W-1]),
        .phy_addr (reg_wdata[2*FLD_W-1:FLD_W]),
        .reg_addr (reg_wdata[FLD_W-1:0]),
        .wr_data  (wdata_q),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_data  (rdata_w)
    );

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && acc_we) |=> $stable(acc_q));
    p_no_start_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !busy) |=> !busy);
    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && en_q && !busy) |=> busy);
    p_end_mdc_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !mdc);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        busy, mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    // PHY responder state
    int          cap_n = 0;
    logic [63:0] cap_bit;
    logic [63:0] cap_oe;
    logic        rd_mode = 1'b0;
    logic [15:0] phy_val = 16'h0;

    mdio_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #5 clk = ~clk;

    // PHY model: record the line at each MDC rise, present read bits afterwards.
    always @(posedge mdc) begin
        #1;
        if (cap_n < 64) begin
            cap_bit[63-cap_n] = mdio_o;
            cap_oe[63-cap_n]  = mdio_oe;
        end
        cap_n = cap_n + 1;
        if (rd_mode && cap_n >= 48 && cap_n < 64)
            mdio_i = phy_val[63-cap_n];
        else
            mdio_i = 1'b1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic run_frame(input int div, input bit isrd, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] dat, input bit inject);
        logic [63:0] exp_bits;
        logic [63:0] exp_oe;
        logic [15:0] acc;
        logic [15:0] v;
        int cnt;
        int bad_bits;
        wr(2'd0, 16'h0040 | 16'(div));
        if (!isrd) wr(2'd1, dat);
        cap_n = 0; rd_mode = isrd; phy_val = dat;
        acc = {5'b0, isrd, phy, rg};
        wr(2'd2, acc);
        chk(busy == 1'b1, "R10 busy after access write", busy, 1);
        cnt = 0;
        while (busy && cnt < 20000) begin
            if (inject && cnt == 20) begin
                reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = ~acc & 16'h07FF;
            end else begin
                reg_we = 1'b0;
            end
            cnt++;
            @(negedge clk);
        end
        reg_we = 1'b0;
        chk(cnt == 128*(div+1), "R3 busy length", cnt, 128*(div+1));
        chk(cap_n == 64, "R3 MDC periods per frame", cap_n, 64);
        exp_bits = {32'hFFFF_FFFF, 2'b01, isrd ? 2'b10 : 2'b01, phy, rg,
                    2'b10, isrd ? 16'h0 : dat};
        exp_oe = isrd ? {{46{1'b1}}, 18'h0} : {64{1'b1}};
        bad_bits = 0;
        for (int k = 0; k < 64; k++)
            if (exp_oe[k] && cap_bit[k] !== exp_bits[k]) bad_bits++;
        if (isrd)
            chk(bad_bits == 0, "R6 read frame header bits", cap_bit[63:18], exp_bits[63:18]);
        else
            chk(bad_bits == 0, "R4 write frame bits", cap_bit, exp_bits);
        chk(cap_oe === exp_oe, isrd ? "R6 read line release" : "R4 write drive enable",
            cap_oe, exp_oe);
        #1;
        chk(!mdc && !mdio_oe, "R7 idle mdc and oe low", {mdc, mdio_oe}, 0);
        if (isrd) begin
            rd(2'd3, v);
            chk(v == dat, "R6 read data", v, dat);
        end
        if (inject) begin
            rd(2'd2, v);
            chk(v == acc, "R9 access kept while busy", v, acc);
        end
    endtask

    initial begin
        #1_900_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int divs[4] = '{1, 2, 3, 7};
        logic [4:0]  pp[5] = '{5'h00, 5'h1F, 5'h15, 5'h0A, 5'h01};
        logic [4:0]  rr[5] = '{5'h00, 5'h1F, 5'h0A, 5'h15, 5'h10};
        logic [15:0] dd[5] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h5A5A, 16'h8001};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v);
        chk(v == 16'h003F, "R1 control reset value", v, 16'h003F);
        chk(!busy && !mdc && !mdio_oe, "R1 outputs after reset", {busy, mdc, mdio_oe}, 0);

        // R2 control readback
        wr(2'd0, 16'h0045);
        rd(2'd0, v);
        chk(v == 16'h0045, "R2 control readback", v, 16'h0045);
        wr(2'd1, 16'h1234);
        rd(2'd1, v);
        chk(v == 16'h1234, "R2 write-data readback", v, 16'h1234);

        // R8 disabled: no frame
        wr(2'd0, 16'h0003);
        cap_n = 0;
        wr(2'd2, 16'h0123);
        repeat (300) @(negedge clk);
        chk(!busy && cap_n == 0 && !mdio_oe, "R8 no frame while disabled",
            {busy, 8'(cap_n), mdio_oe}, 0);

        // R3 default divisor frame
        wr(2'd0, 16'h007F);
        run_frame(63, 1'b0, 5'h11, 5'h02, 16'hC3C3, 1'b0);

        // Sweep over divisors and patterns
        foreach (divs[i])
            for (int p = 0; p < 5; p++) begin
                run_frame(divs[i], 1'b0, pp[p], rr[p], dd[p], 1'b0);
                run_frame(divs[i], 1'b1, pp[p], rr[p], dd[(p+2)%5], 1'b0);
            end

        // R9 mid-frame access write ignored
        run_frame(2, 1'b1, 5'h0C, 5'h13, 16'h3C96, 1'b1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule